// File: doc/BRIEF.md
# Six-Step Accumulator Processor Core

This block is a small 8-bit accumulator machine that runs a program held in a 16-byte internal memory. Each memory byte can be an instruction or a data operand. An instruction's upper nibble selects the operation and its lower nibble names a memory location. The datapath has these registers:

- a 4-bit program counter
- a memory address register
- an instruction register
- an accumulator (A)
- an operand register (B)
- an output register

All of them exchange values over one shared 8-bit internal bus. That bus is a priority multiplexer, so the core contains no tri-state logic.

A one-hot ring counter divides time into six steps, and every instruction occupies all six. The first two steps always fetch the instruction: the address register takes the program counter, then the instruction register takes the memory byte and the counter advances. The remaining steps execute the instruction or idle. A halt instruction stops all activity until the next reset. While reset is held, a loader fills the memory through a separate write port. Reset never disturbs the memory contents, so a program can be restarted without reloading it.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the program counter, A, B, the address register, the instruction register, the output register and the halt state return to zero, and the ring counter returns to its first step. Execution then starts at address 0 on the first edge with `rst_n` high.
- R2: An instruction byte carries the opcode in bits [7:4] and an operand memory address in bits [3:0].
- R3: Opcode 0x0 loads A with the byte stored at the operand address.
- R4: Opcode 0x1 adds the operand byte to A, modulo 256, with no carry kept.
- R5: Opcode 0x2 subtracts the operand byte from A, modulo 256, with no borrow kept.
- R6: Opcode 0xE copies A into the output register. For the instruction that starts at edge 6k after reset release, `out_val` changes after edge 6k+2, which is edge number 6k+3 counted from 1.
- R7: Opcode 0xF enters a halt state that lasts until reset. No later instruction executes and `out_val` stays frozen.
- R8: Opcodes 0x3 through 0xD change no register other than the fetch registers.
- R9: Every instruction lasts exactly six clock cycles, whatever its opcode.
- R10: The program counter wraps from 15 back to 0.
- R11: When `ld_we` is high at a clock edge, `ld_data` is written to memory location `ld_addr`. This works during reset, and reset never clears the memory.
- R12: At most one source drives the internal bus in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_we | input | 1 | Loader write strobe |
| ld_addr | input | 4 | Loader write address |
| ld_data | input | 8 | Loader write data |
| out_val | output | 8 | Current output register value |

## Verification
The bench builds the core at its default widths: an 8-bit data path and 4-bit addresses. With these widths the whole memory is only sixteen bytes. A program that reaches address 15 and wraps back to 0 then finishes within about a hundred cycles, and one image can exercise every unused opcode as a filler. The 8-bit width keeps the operand space small enough for a dense grid of addend and subtrahend pairs, including the overflow and underflow cases at 255 and 0. The bench computes expected sums and differences modulo 256 and predicts the exact edge at which each output write lands.

// File: rtl/acc_cpu_pkg.sv
// Package: shared opcode values and the control-word layout for the
// accumulator core. Assumes an opcode field of four bits.
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_LOAD = 4'h0;
    localparam logic [OPC_W-1:0] OPC_ADD  = 4'h1;
    localparam logic [OPC_W-1:0] OPC_SUB  = 4'h2;
    localparam logic [OPC_W-1:0] OPC_EMIT = 4'hE;
    localparam logic [OPC_W-1:0] OPC_STOP = 4'hF;

    // One control word per cycle: bus drivers first, then register loads.
    typedef struct packed {
        logic pc_oe;
        logic mem_oe;
        logic ir_oe;
        logic acc_oe;
        logic alu_oe;
        logic mar_ld;
        logic ir_ld;
        logic pc_inc;
        logic acc_ld;
        logic opnd_ld;
        logic out_ld;
        logic alu_sub;
    } ctrl_word_t;

endpackage

// File: rtl/acc_ring.sv
// Module: one-hot step sequencer. Rotates a single set bit through STEPS
// positions while run is high. Assumes STEPS >= 2.
module acc_ring #(
    parameter int STEPS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [STEPS-1:0] step
);

    localparam logic [STEPS-1:0] FIRST = {{(STEPS-1){1'b0}}, 1'b1};

    // Rotate the active step left each cycle; park on the first step in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            step <= FIRST;
        else if (run)
            step <= {step[STEPS-2:0], step[STEPS-1]};
    end

    AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(step)); // R9

    AST_RING_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step[STEPS-1]) |=> step[0]); // R9

endmodule

// File: rtl/acc_ctrl.sv
// Module: hardwired decoder. Maps the active step and the opcode to a control
// word, and holds the halt state. Assumes six steps, with steps 0 and 1 fixed
// for fetch.
module acc_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int STEPS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STEPS-1:0] step,
    input  logic [OPC_W-1:0] opcode,
    output ctrl_word_t       cw,
    output logic             halted
);

    localparam logic [STEPS-1:0] S_F0 = STEPS'(1) << 0;
    localparam logic [STEPS-1:0] S_F1 = STEPS'(1) << 1;
    localparam logic [STEPS-1:0] S_X0 = STEPS'(1) << 2;
    localparam logic [STEPS-1:0] S_X1 = STEPS'(1) << 3;
    localparam logic [STEPS-1:0] S_X2 = STEPS'(1) << 4;

    logic is_mem_op;

    // Classify opcodes that read a memory operand.
    always_comb is_mem_op = (opcode == OPC_LOAD) || (opcode == OPC_ADD) || (opcode == OPC_SUB);

    // Decode the control word for the current step; idle when halted.
    always_comb begin
        cw = '0;
        if (!halted) begin
            case (step)
                S_F0: begin cw.pc_oe = 1'b1; cw.mar_ld = 1'b1; end
                S_F1: begin cw.mem_oe = 1'b1; cw.ir_ld = 1'b1; cw.pc_inc = 1'b1; end
                S_X0: begin
                    if (is_mem_op) begin cw.ir_oe = 1'b1; cw.mar_ld = 1'b1; end
                    else if (opcode == OPC_EMIT) begin cw.acc_oe = 1'b1; cw.out_ld = 1'b1; end
                end
                S_X1: begin
                    if (opcode == OPC_LOAD) begin cw.mem_oe = 1'b1; cw.acc_ld = 1'b1; end
                    else if (is_mem_op) begin cw.mem_oe = 1'b1; cw.opnd_ld = 1'b1; end
                end
                S_X2: begin
                    if (opcode == OPC_ADD || opcode == OPC_SUB) begin
                        cw.alu_oe  = 1'b1;
                        cw.acc_ld  = 1'b1;
                        cw.alu_sub = (opcode == OPC_SUB);
                    end
                end
                default: cw = '0;
            endcase
        end
    end

    // Latch the halt state on the first execute step of a stop instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halted <= 1'b0;
        else if (step == S_X0 && opcode == OPC_STOP)
            halted <= 1'b1;
    end

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R7

    AST_BUS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cw.pc_oe, cw.mem_oe, cw.ir_oe, cw.acc_oe, cw.alu_oe})); // R12

endmodule

// File: rtl/acc_ram.sv
// Module: small program and data memory with an asynchronous read port and
// one synchronous write port. Has no reset, so its contents survive a reset.
module acc_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the write data on the clock edge when the strobe is high.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Return the addressed byte combinationally.
    always_comb rdata = mem[raddr];

endmodule

// File: rtl/acc_alu.sv
// Module: wrap-around adder and subtractor. Keeps no carry or borrow.
module acc_alu #(
    parameter int DATA_W = 8
) (
    input  logic              sub,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    // Add b, or its two's complement, modulo 2**DATA_W.
    always_comb y = sub ? (a - b) : (a + b);

endmodule

// File: rtl/acc_cpu_core.sv
// Module: top of the accumulator core. Holds the datapath registers and the
// shared priority-mux bus. Assumes the opcode field fills the data bits above
// the ADDR_W-bit operand field.
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int STEPS  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic [DATA_W-1:0] out_val
);

    localparam int PAD = DATA_W - ADDR_W;

    logic [STEPS-1:0]  step;
    ctrl_word_t        cw;
    logic              halted;
    logic [ADDR_W-1:0] pc_q, mar_q;
    logic [DATA_W-1:0] ir_q, acc_q, opnd_q, out_q;
    logic [DATA_W-1:0] mem_rd, alu_y, bus;

    acc_ring #(.STEPS(STEPS)) u_ring (
        .clk(clk), .rst_n(rst_n), .run(!halted), .step(step)
    );

    acc_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .step(step),
        .opcode(ir_q[DATA_W-1 -: OPC_W]), .cw(cw), .halted(halted)
    );

    acc_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .we(ld_we), .waddr(ld_addr), .wdata(ld_data),
        .raddr(mar_q), .rdata(mem_rd)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .sub(cw.alu_sub), .a(acc_q), .b(opnd_q), .y(alu_y)
    );

    // Shared bus: the first enabled source in fixed priority order wins.
    always_comb begin
        if (cw.pc_oe)       bus = {{PAD{1'b0}}, pc_q};
        else if (cw.mem_oe) bus = mem_rd;
        else if (cw.ir_oe)  bus = {{PAD{1'b0}}, ir_q[ADDR_W-1:0]};
        else if (cw.acc_oe) bus = acc_q;
        else if (cw.alu_oe) bus = alu_y;
        else                bus = '0;
    end

    // Datapath registers load from the bus under control-word strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            mar_q  <= '0;
            ir_q   <= '0;
            acc_q  <= '0;
            opnd_q <= '0;
            out_q  <= '0;
        end else begin
            if (cw.pc_inc)  pc_q   <= pc_q + 1'b1;
            if (cw.mar_ld)  mar_q  <= bus[ADDR_W-1:0];
            if (cw.ir_ld)   ir_q   <= bus;
            if (cw.acc_ld)  acc_q  <= bus;
            if (cw.opnd_ld) opnd_q <= bus;
            if (cw.out_ld)  out_q  <= bus;
        end
    end

    // Present the output register at the port.
    always_comb out_val = out_q;

    AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(out_q)); // R7

    AST_PC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cw.pc_inc && pc_q == '1) |=> (pc_q == '0)); // R10

    AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (step[0] && !halted) |=> (mar_q == $past(pc_q))); // R9

endmodule

// File: tb/tb_acc_cpu_core.sv
module tb_acc_cpu_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_we = 1'b0;
    logic [3:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [7:0] out_val;

    int errors = 0;
    int checks = 0;
    int edges_done = 0;
    logic [7:0] img [16];

    acc_cpu_core dut (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data), .out_val(out_val)
    );

    always #10 clk = ~clk;

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: out_val got %0h expected %0h (edge %0d)", req, got, exp, edges_done);
        end
    endtask

    // Hold reset, optionally load the image, release reset at a falling edge.
    task automatic start_prog(input bit do_load);
        @(negedge clk);
        rst_n = 1'b0;
        if (do_load) begin
            for (int i = 0; i < 16; i++) begin
                ld_we = 1'b1;
                ld_addr = i[3:0];
                ld_data = img[i];
                @(negedge clk);
            end
        end
        ld_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        edges_done = 0;
    endtask

    task automatic run_to(input int n);
        while (edges_done < n) begin
            @(posedge clk);
            edges_done++;
        end
        @(negedge clk);
    endtask

    initial begin
        // Example program: load 14, add 15, emit, stop.
        for (int i = 0; i < 16; i++) img[i] = 8'h00;
        img[0] = 8'h0E; img[1] = 8'h1F; img[2] = 8'hE0; img[3] = 8'hF0;
        img[14] = 8'd5; img[15] = 8'd3;
        start_prog(1'b1);
        check("R1 reset", out_val, 8'h00);
        run_to(14); check("R6 not yet", out_val, 8'h00);
        run_to(15); check("R3 R4 R6 example", out_val, 8'd8);
        run_to(40); check("R7 halt", out_val, 8'd8);

        // Sweep operands: load, add, emit, subtract, emit, stop, then dead code.
        for (int x = 0; x < 256; x += 15) begin
            for (int y = 0; y < 256; y += 17) begin
                logic [7:0] s, d, z;
                z = 8'((x * 7 + y * 3 + 1) % 256);
                s = 8'(x + y);
                d = s - z;
                for (int i = 0; i < 16; i++) img[i] = 8'h00;
                img[0] = 8'h0E; img[1] = 8'h1F; img[2] = 8'hE0; img[3] = 8'h2D;
                img[4] = 8'hE0; img[5] = 8'hF0; img[6] = 8'h0C; img[7] = 8'hE0;
                img[12] = ~d; img[13] = z; img[14] = 8'(x); img[15] = 8'(y);
                start_prog(1'b1);
                run_to(15); check("R4 add wrap", out_val, s);
                run_to(26); check("R9 six steps", out_val, s);
                run_to(27); check("R5 sub wrap", out_val, d);
                run_to(60); check("R7 frozen after halt", out_val, d);
            end
        end

        // Wrap program: filler opcodes 0x3..0xD, address 15 holds a load of address 3.
        img[0] = 8'h1F; img[1] = 8'hE0;
        for (int k = 2; k <= 12; k++) img[k] = 8'((k + 1) << 4);
        img[13] = 8'h30; img[14] = 8'h30; img[15] = 8'h03;
        start_prog(1'b1);
        run_to(8);   check("R1 zero acc", out_val, 8'h00);
        run_to(9);   check("R2 add field 15", out_val, 8'h03);
        run_to(104); check("R8 filler opcodes idle", out_val, 8'h03);
        run_to(105); check("R10 pc wrap", out_val, 8'h43);

        // Restart without loading: memory must survive reset.
        start_prog(1'b0);
        check("R1 reset clears out", out_val, 8'h00);
        run_to(9);   check("R11 memory kept", out_val, 8'h03);
        run_to(105); check("R11 R10 rerun", out_val, 8'h43);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule